// File: doc/BRIEF.md
# Masked Vector Half-Precision to Unsigned Word Converter

This block turns up to sixteen half-precision floating-point lanes into unsigned 32-bit integers in one registered step. A 256-bit source vector supplies sixteen 16-bit elements. A length select chooses how many lanes take part: 4, 8 or 16. Every destination bit above the selected length comes out as zero.

Each active lane is governed by a per-lane write mask, which can be switched off entirely. A lane whose mask bit is clear is either cleared or keeps its previous destination value, chosen by a zeroing/merging input. When a memory source is broadcast, every lane converts element 0. The rounding mode normally comes from a global field. An embedded field overrides it only for a register source at full length with the broadcast/override bit set.

Conversion results that are not exact set a sticky precision flag. Results that cannot be represented (NaN, infinities, and negatives that do not round to zero) return all ones and set a sticky invalid flag. Both flags clear only on reset.

Top module: `fp16_u32_vec_cvt`

## Requirements
- R1: A request with `in_valid` high shows up on `result` and `out_valid` exactly one clock later. Without a request, `out_valid` is low and `result` holds.
- R2: `vlen_sel` 00, 01, 10 and 11 give 4, 8, 16 and 16 active lanes. Result bits above the active lanes read zero.
- R3: The embedded rounding field is used only when `src_is_mem`=0, the length is full (16 lanes) and `bcast`=1. In all other cases the global rounding field is used.
- R4: When `src_is_mem`=1 and `bcast`=1, every active lane converts source bits [15:0]. Otherwise lane j converts source bits [16j+15:16j].
- R5: An active lane is written with its converted value when `mask_en`=0 or its `lane_mask` bit is 1. A clear mask bit gives 0 when `zero_mode`=1, and otherwise the lane's 32 bits of `dest_prev`.
- R6: Input lanes decode as sign [15], exponent [14:10] with bias 15, and fraction [9:0]. Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Subnormals give 0 or 1 according to the mode.
- R7: A written lane that is inexact and not invalid sets `flag_precision`.
- R8: A written lane holding NaN, either infinity, or a negative value whose rounded magnitude is nonzero returns 0xFFFFFFFF and sets `flag_invalid` (not `flag_precision`).
- R9: A negative input that rounds to zero returns 0 without invalid. It sets precision only when inexact.
- R10: Lanes that are inactive or not written raise no flag.
- R11: Reset clears `result`, `out_valid` and both flags. Once set, a flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src | input | 256 | Sixteen half-precision source elements |
| vlen_sel | input | 2 | Vector length select |
| lane_mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply `lane_mask` |
| zero_mode | input | 1 | 1 = clear unwritten lanes, 0 = merge |
| bcast | input | 1 | Broadcast / embedded-control bit |
| src_is_mem | input | 1 | 1 = source is memory |
| rc_embed | input | 2 | Embedded rounding field |
| rc_global | input | 2 | Global rounding field |
| dest_prev | input | 512 | Previous destination value |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Converted destination |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_precision | output | 1 | Sticky precision flag |

## Verification
Some checks run on every cycle:
- the one-cycle latency and the hold while idle;
- that the lanes above a 128-bit length read zero;
- that a cleared lane 0 reads zero in zeroing mode;
- that the flags stay set and that a request writing no lane leaves them alone;
- that the active lanes form a contiguous run starting at lane 0.

The numeric behaviour can only be shown by the bench's scenarios. This covers the rounding in each mode, the halfway and subnormal cases, the invalid returns, which rounding field is picked, and broadcast against per-lane sourcing. The bench checks each of these against its own arithmetic model, lane by lane.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;
endpackage

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
   import fcvt_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int MIN_LANES = 4,
   parameter int SEL_W     = 2
) (
   input  logic [SEL_W-1:0] vlen_sel,
   input  logic             src_is_mem,
   input  logic             bcast,
   input  logic [1:0]       rc_embed,
   input  logic [1:0]       rc_global,
   output rmode_e           rm,
   output logic [LANES-1:0] lane_on,
   output logic             elem0_all
);
   localparam int CW = 32;

   logic [CW-1:0] n_req;
   logic [CW-1:0] n_eff;
   logic          full_len;
   logic          use_emb;

   // requested lane count, clamped to the lanes that exist
   assign n_req    = CW'(MIN_LANES) << vlen_sel;
   assign n_eff    = (n_req > CW'(LANES)) ? CW'(LANES) : n_req;
   assign full_len = (n_eff == CW'(LANES));

   for (genvar j = 0; j < LANES; j++) begin : g_on
      assign lane_on[j] = (CW'(j) < n_eff);
   end

   assign use_emb   = !src_is_mem && bcast && full_len;
   assign rm        = rmode_e'(use_emb ? rc_embed : rc_global);
   assign elem0_all = src_is_mem && bcast;

   // R2: active lanes are always a contiguous run starting at lane 0
   logic [LANES:0] pref_chk;
   assign pref_chk = {1'b0, lane_on} + {{LANES{1'b0}}, 1'b1};
   always_comb begin
      p_lane_prefix_r2: assert ($onehot0(pref_chk));
   end
endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane
   import fcvt_pkg::*;
#(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10,
   parameter int OUT_W  = 32,
   localparam int IN_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [IN_W-1:0]  op,
   input  rmode_e           rm,
   output logic [OUT_W-1:0] res,
   output logic             inv,
   output logic             inexact
);
   localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
   localparam int MANT_W   = FRAC_W + 1;
   localparam int FIX_FRAC = BIAS - 1 + FRAC_W;   // weight of the smallest subnormal
   localparam int INT_W    = BIAS + 1;            // bits of the largest finite integer part
   localparam int FIX_W    = INT_W + FIX_FRAC;

   if (INT_W + 1 > OUT_W) begin : g_bad_width
      $error("fcvt_lane: OUT_W too narrow for the input format");
   end
   if (FIX_FRAC < 2) begin : g_bad_frac
      $error("fcvt_lane: format too small");
   end

   logic               sgn;
   logic [EXP_W-1:0]   ex;
   logic [FRAC_W-1:0]  fr;
   logic               is_special;
   logic               is_sub;
   logic [MANT_W-1:0]  mant;
   logic [EXP_W-1:0]   shamt;
   logic [FIX_W-1:0]   fix;
   logic [INT_W-1:0]   ipart;
   logic               guard;
   logic               sticky;
   logic               lost;
   logic               up;
   logic [INT_W:0]     mag;
   logic               neg_bad;

   assign sgn        = op[IN_W-1];
   assign ex         = op[IN_W-2 -: EXP_W];
   assign fr         = op[FRAC_W-1:0];
   assign is_special = &ex;
   assign is_sub     = ~|ex;

   // fixed point value with FIX_FRAC fraction bits
   assign mant  = {~is_sub, fr};
   assign shamt = is_sub ? '0 : ex - EXP_W'(1);
   assign fix   = FIX_W'(mant) << shamt;

   assign ipart  = fix[FIX_W-1:FIX_FRAC];
   assign guard  = fix[FIX_FRAC-1];
   assign sticky = |fix[FIX_FRAC-2:0];
   assign lost   = guard | sticky;

   always_comb begin
      unique case (rm)
         RM_NEAR: up = guard & (sticky | ipart[0]);
         RM_DOWN: up = sgn & lost;
         RM_UP:   up = ~sgn & lost;
         default: up = 1'b0;
      endcase
   end

   assign mag     = {1'b0, ipart} + {{INT_W{1'b0}}, up};
   assign neg_bad = sgn & (|mag);
   assign inv     = is_special | neg_bad;
   assign inexact = ~inv & lost;

   always_comb begin
      if (inv)      res = '1;
      else if (sgn) res = '0;
      else          res = OUT_W'(mag);
   end
endmodule

// File: rtl/fcvt_pick.sv
module fcvt_pick #(
   parameter int OUT_W = 32
) (
   input  logic             on,
   input  logic             wr_req,
   input  logic             zero_mode,
   input  logic [OUT_W-1:0] conv,
   input  logic [OUT_W-1:0] prev,
   output logic [OUT_W-1:0] val,
   output logic             wr_eff
);
   assign wr_eff = on & wr_req;

   always_comb begin
      if (!on)            val = '0;
      else if (wr_req)    val = conv;
      else if (zero_mode) val = '0;
      else                val = prev;
   end
endmodule

// File: rtl/fp16_u32_vec_cvt.sv
module fp16_u32_vec_cvt
   import fcvt_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int MIN_LANES = 4,
   parameter int SEL_W     = 2,
   parameter int EXP_W     = 5,
   parameter int FRAC_W    = 10,
   parameter int OUT_W     = 32,
   localparam int IN_W     = 1 + EXP_W + FRAC_W,
   localparam int SRC_W    = LANES * IN_W,
   localparam int DST_W    = LANES * OUT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SRC_W-1:0] src,
   input  logic [SEL_W-1:0] vlen_sel,
   input  logic [LANES-1:0] lane_mask,
   input  logic             mask_en,
   input  logic             zero_mode,
   input  logic             bcast,
   input  logic             src_is_mem,
   input  logic [1:0]       rc_embed,
   input  logic [1:0]       rc_global,
   input  logic [DST_W-1:0] dest_prev,
   output logic             out_valid,
   output logic [DST_W-1:0] result,
   output logic             flag_invalid,
   output logic             flag_precision
);
   localparam int LOW_W = MIN_LANES * OUT_W;

   if (LANES % MIN_LANES != 0 || MIN_LANES < 1) begin : g_bad_lanes
      $error("fp16_u32_vec_cvt: LANES must be a multiple of MIN_LANES");
   end
   if (LANES <= MIN_LANES) begin : g_bad_min
      $error("fp16_u32_vec_cvt: need more than one length step");
   end

   rmode_e           rm;
   logic [LANES-1:0] lane_on;
   logic             elem0_all;
   logic [LANES-1:0] lane_wr;
   logic [LANES-1:0] lane_inv;
   logic [LANES-1:0] lane_inx;
   logic [DST_W-1:0] next_res;

   fcvt_ctrl #(
      .LANES(LANES), .MIN_LANES(MIN_LANES), .SEL_W(SEL_W)
   ) u_ctrl (
      .vlen_sel  (vlen_sel),
      .src_is_mem(src_is_mem),
      .bcast     (bcast),
      .rc_embed  (rc_embed),
      .rc_global (rc_global),
      .rm        (rm),
      .lane_on   (lane_on),
      .elem0_all (elem0_all)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [IN_W-1:0]  elem;
      logic [OUT_W-1:0] conv;
      logic             inv;
      logic             inx;

      assign elem = elem0_all ? src[IN_W-1:0] : src[j*IN_W +: IN_W];

      fcvt_lane #(
         .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)
      ) u_cvt (
         .op     (elem),
         .rm     (rm),
         .res    (conv),
         .inv    (inv),
         .inexact(inx)
      );

      fcvt_pick #(.OUT_W(OUT_W)) u_pick (
         .on       (lane_on[j]),
         .wr_req   (lane_mask[j] | ~mask_en),
         .zero_mode(zero_mode),
         .conv     (conv),
         .prev     (dest_prev[j*OUT_W +: OUT_W]),
         .val      (next_res[j*OUT_W +: OUT_W]),
         .wr_eff   (lane_wr[j])
      );

      assign lane_inv[j] = inv & lane_wr[j];
      assign lane_inx[j] = inx & lane_wr[j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         result         <= '0;
         flag_invalid   <= 1'b0;
         flag_precision <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result         <= next_res;
            flag_invalid   <= flag_invalid | (|lane_inv);
            flag_precision <= flag_precision | (|lane_inx);
         end
      end
   end

   // R1: a request appears one clock later
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1: no request, no strobe, result holds
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));
   // R2: shortest length leaves the upper lanes clear
   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vlen_sel == '0) |=> (result[DST_W-1:LOW_W] == '0));
   // R5: an unwritten lane 0 in zeroing mode reads zero
   p_zero_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !lane_mask[0] && zero_mode) |=> (result[OUT_W-1:0] == '0));
   // R10: a request that writes no lane leaves clear flags clear
   p_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_wr == '0 && !flag_invalid && !flag_precision)
      |=> (!flag_invalid && !flag_precision));
   // R11: flags are sticky
   p_sticky_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_invalid |=> flag_invalid);
   p_sticky_prec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_precision |=> flag_precision);
endmodule

// File: tb/fp16_u32_vec_cvt_test.sv
`timescale 1ns/1ps
module fp16_u32_vec_cvt_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [255:0] src = '0;
   logic [1:0]   vlen_sel = '0;
   logic [15:0]  lane_mask = '0;
   logic         mask_en = 1'b0;
   logic         zero_mode = 1'b0;
   logic         bcast = 1'b0;
   logic         src_is_mem = 1'b0;
   logic [1:0]   rc_embed = '0;
   logic [1:0]   rc_global = '0;
   logic [511:0] dest_prev = '0;
   logic         out_valid;
   logic [511:0] result;
   logic         flag_invalid;
   logic         flag_precision;

   always #4 clk = ~clk;   // 125 MHz

   fp16_u32_vec_cvt uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
      .vlen_sel(vlen_sel), .lane_mask(lane_mask), .mask_en(mask_en),
      .zero_mode(zero_mode), .bcast(bcast), .src_is_mem(src_is_mem),
      .rc_embed(rc_embed), .rc_global(rc_global), .dest_prev(dest_prev),
      .out_valid(out_valid), .result(result),
      .flag_invalid(flag_invalid), .flag_precision(flag_precision)
   );

   typedef struct {
      logic [511:0] res;
      bit           inv;
      bit           prec;
      string        tag;
   } item_t;

   item_t q[$];
   item_t mon_it;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    st_inv = 0;
   bit    st_prec = 0;
   bit    done = 0;

   task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent model: exact rational arithmetic on the scaled value
   function automatic void ref_conv(input logic [15:0] h, input logic [1:0] rmc,
                                    output logic [31:0] r, output bit inv, output bit prec);
      bit     s;
      int     e;
      int     sh;
      longint num, qv, rem, half;
      bit     up;
      s = h[15];
      e = int'(h[14:10]);
      inv = 0; prec = 0; r = '0;
      if (e == 31) begin inv = 1; r = 32'hFFFF_FFFF; return; end
      if (e == 0) begin num = longint'(h[9:0]); sh = 24; end
      else begin num = 1024 + longint'(h[9:0]); sh = 25 - e; end
      if (sh <= 0) begin qv = num <<< (-sh); rem = 0; half = 1; end
      else begin
         qv = num >>> sh;
         rem = num - (qv <<< sh);
         half = longint'(1) <<< (sh - 1);
      end
      case (rmc)
         2'b00:   up = (rem > half) || (rem == half && qv[0]);
         2'b01:   up = s && (rem != 0);
         2'b10:   up = !s && (rem != 0);
         default: up = 0;
      endcase
      qv = qv + longint'(up);
      if (s && qv != 0) begin inv = 1; r = 32'hFFFF_FFFF; return; end
      prec = (rem != 0);
      r = s ? 32'd0 : qv[31:0];
   endfunction

   task automatic send(input string tag, input logic [255:0] s, input logic [1:0] vs,
                       input logic [15:0] m, input bit men, input bit zm, input bit bc,
                       input bit mem, input logic [1:0] re, input logic [1:0] rg,
                       input logic [511:0] prev);
      item_t       it;
      int          n;
      logic [1:0]  rmc;
      logic [15:0] e;
      logic [31:0] r;
      bit          iv, pc;
      n   = (vs == 2'b00) ? 4 : (vs == 2'b01) ? 8 : 16;
      rmc = (!mem && n == 16 && bc) ? re : rg;
      it.res = '0;
      for (int j = 0; j < 16; j++) begin
         if (j < n) begin
            if (!men || m[j]) begin
               e = (mem && bc) ? s[15:0] : s[16*j +: 16];
               ref_conv(e, rmc, r, iv, pc);
               it.res[32*j +: 32] = r;
               st_inv  = st_inv | iv;
               st_prec = st_prec | pc;
            end else if (!zm) begin
               it.res[32*j +: 32] = prev[32*j +: 32];
            end
         end
      end
      it.inv = st_inv; it.prec = st_prec; it.tag = tag;
      q.push_back(it);
      src = s; vlen_sel = vs; lane_mask = m; mask_en = men; zero_mode = zm;
      bcast = bc; src_is_mem = mem; rc_embed = re; rc_global = rg; dest_prev = prev;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: compare each result as the design presents it
   always @(negedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1 unexpected out_valid actual=1 expected=0");
         end else begin
            mon_it = q.pop_front();
            check({mon_it.tag, " result"}, result, mon_it.res);
            check({mon_it.tag, " flags"}, {510'd0, flag_invalid, flag_precision},
                  {510'd0, mon_it.inv, mon_it.prec});
         end
      end
   end

   task automatic do_reset();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R11 reset result", result, '0);
      check("R11 reset strobe/flags", {509'd0, out_valid, flag_invalid, flag_precision}, '0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      st_inv = 0; st_prec = 0;
   endtask

   function automatic logic [255:0] fill(input logic [15:0] h);
      return {16{h}};
   endfunction

   initial begin
      logic [255:0] s;
      logic [511:0] ones;
      logic [511:0] held;
      ones = '1;
      do_reset();

      // R6: exact values, full length, no flags expected
      s = fill(16'h3C00);
      s[15:0] = 16'h3C00; s[31:16] = 16'h4000; s[47:32] = 16'h7BFF;
      s[63:48] = 16'h0000; s[79:64] = 16'h8000; s[95:80] = 16'h6400;
      send("R6 exact", s, 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'b00, '0);

      // R6 R7: halfway, subnormal and fractional cases in each mode
      s = fill(16'h3E00);
      s[15:0] = 16'h4100; s[31:16] = 16'h4300; s[47:32] = 16'h3800;
      s[63:48] = 16'h0001; s[79:64] = 16'h03FF; s[95:80] = 16'h3BFF;
      for (int k = 0; k < 4; k++)
         send("R6 R7 rounding", s, 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'(k), '0);
      do_reset();

      // R9: negative that rounds to zero
      send("R9 neg to zero rne", fill(16'hB800), 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'b00, '0);
      send("R9 neg to zero trunc", fill(16'hB400), 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'b11, '0);
      send("R9 neg zero exact", fill(16'h8000), 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'b01, '0);
      do_reset();

      // R8: invalid inputs
      s = fill(16'h3C00);
      s[15:0] = 16'h7E00; s[31:16] = 16'h7C00; s[47:32] = 16'hFC00;
      s[63:48] = 16'hBC00; s[79:64] = 16'hB800;
      send("R8 invalid down", s, 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'b01, '0);
      // R11: invalid stays set across a clean request
      send("R11 sticky", fill(16'h4000), 2'b10, '0, 0, 0, 0, 0, 2'b00, 2'b00, '0);
      do_reset();

      // R10 R5: masked-off NaN lanes raise nothing; merge, then zero, then mask off
      s = fill(16'h7E00);
      for (int j = 4; j < 8; j++) s[16*j +: 16] = 16'h3C00;
      send("R10 R5 merge", s, 2'b10, 16'h00F0, 1, 0, 0, 0, 2'b00, 2'b00, {16{32'hA5A5_0001}});
      send("R10 R5 zeroing", s, 2'b10, 16'h00F0, 1, 1, 0, 0, 2'b00, 2'b00, {16{32'hA5A5_0001}});
      send("R10 nothing written", s, 2'b10, 16'h0000, 1, 0, 0, 0, 2'b00, 2'b00, ones);
      send("R5 mask disabled", fill(16'h4400), 2'b10, 16'h0000, 0, 1, 0, 0, 2'b00, 2'b00, ones);

      // R2: lengths with merge from all-ones destination
      for (int k = 0; k < 4; k++)
         send("R2 length", fill(16'h4000), 2'(k), 16'h0005, 1, 0, 0, 0, 2'b00, 2'b00, ones);
      // R10: lanes beyond the length hold NaN and raise nothing
      do_reset();
      s = fill(16'h7E00);
      for (int j = 0; j < 4; j++) s[16*j +: 16] = 16'h4000;
      send("R10 R2 inactive NaN", s, 2'b00, '0, 0, 0, 0, 0, 2'b00, 2'b00, '0);

      // R3: rounding source selection on 2.5
      send("R3 embedded used", fill(16'h4100), 2'b10, '0, 0, 0, 1, 0, 2'b10, 2'b00, '0);
      send("R3 global mem", fill(16'h4100), 2'b10, '0, 0, 0, 1, 1, 2'b10, 2'b00, '0);
      send("R3 global short", fill(16'h4100), 2'b01, '0, 0, 0, 1, 0, 2'b10, 2'b00, '0);
      send("R3 global nobc", fill(16'h4100), 2'b10, '0, 0, 0, 0, 0, 2'b10, 2'b00, '0);
      send("R3 sel11 full", fill(16'h4100), 2'b11, '0, 0, 0, 1, 0, 2'b10, 2'b00, '0);

      // R4: broadcast against per-lane sourcing
      for (int j = 0; j < 16; j++) s[16*j +: 16] = 16'h3C00 + 16'(j * 64);
      send("R4 mem bcast", s, 2'b10, '0, 0, 0, 1, 1, 2'b00, 2'b00, '0);
      send("R4 reg bcast", s, 2'b10, '0, 0, 0, 1, 0, 2'b00, 2'b00, '0);
      send("R4 mem nobc", s, 2'b10, '0, 0, 0, 0, 1, 2'b00, 2'b00, '0);

      // R1: idle hold
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      #1;
      held = result;
      repeat (3) @(negedge clk);
      #1;
      check("R1 hold result", result, held);
      check("R1 idle strobe", {511'd0, out_valid}, '0);

      // R5 R6: mixed random traffic, back to back
      for (int n = 0; n < 300; n++) begin
         for (int j = 0; j < 8; j++) s[32*j +: 32] = $urandom;
         for (int j = 0; j < 16; j++) ones[32*j +: 32] = $urandom;
         send("R5 R6 random", s, 2'($urandom), 16'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), ones);
      end

      while (q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule